// File: doc/BRIEF.md
# Process-Tagged Fully Associative Translation Buffer

This block caches page table entries so that a virtual page number can be turned into a physical page number without walking the page tables. Every slot can hold any page, and all slots are compared at once. Each slot also carries an address-space (process) tag. A lookup therefore matches only when both the page number and the process tag agree, and translations of several processes can live side by side across context switches.

A lookup is purely combinational. In the same cycle it reports a hit, the physical page, the stored permission bits and a protection-fault flag. The stored rights are checked against the requested access, and a disallowed access raises a fault instead of a translation. After a miss has been serviced outside the block, the fill port writes a complete entry. The fill lands in a free slot if one exists. Otherwise it goes to the slot named by a rotating victim pointer. A fill of a page/tag pair that is already present rewrites that slot in place. Two single-cycle flushes are provided: one empties the whole buffer, and one removes only the slots of a given process. Page offset bits never reach this block.

Top module: `tagged_tlb`

## Requirements
- R1: After reset every slot is empty, and any lookup returns lk_hit=0, lk_fault=0, lk_ppn=0, lk_perm=0.
- R2: A fill accepted at a clock edge makes a lookup of the same VPN and PID in the following cycle return lk_hit=1 with the filled PPN and permission bits.
- R3: A lookup matches only when both VPN and PID agree. The same VPN under two PIDs can be held at the same time, each with its own PPN.
- R4: Permission bits are bit0 read, bit1 write, bit2 execute. lk_acc encodes 0 read, 1 write, 2 execute, and 3 is never allowed. On a match whose rights forbid the access, lk_fault=1, lk_hit=0 and lk_ppn=0, and lk_perm still shows the stored bits.
- R5: While a free slot exists, a fill never evicts a valid entry. With ENTRIES slots, ENTRIES distinct fills after a reset or a flush all stay resident.
- R6: When all slots are valid, a fill of a new pair replaces slots in rotating order: slot 0 first after reset, then 1, 2 and so on, wrapping after the last. Only such evictions advance the pointer.
- R7: A fill whose VPN and PID already match a valid slot overwrites that slot. No other entry is evicted, the victim pointer does not move, and no lookup ever matches two slots.
- R8: flush_all empties every slot in one cycle. Lookups in the next cycle all miss.
- R9: flush_pid_en with flush_pid empties exactly the slots tagged with that PID in one cycle. Slots of other PIDs keep hitting.
- R10: A fill presented in the same cycle as either flush is discarded.
- R11: lk_hit and lk_fault are never high together. On a miss, both are low and lk_ppn and lk_perm are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_pid | input | PID_W | Lookup process tag |
| lk_acc | input | 2 | Requested access: 0 read, 1 write, 2 execute |
| lk_hit | output | 1 | Match with permitted access |
| lk_fault | output | 1 | Match with forbidden access |
| lk_ppn | output | PPN_W | Physical page number, zero unless lk_hit |
| lk_perm | output | 3 | Stored rights of the matching slot |
| fill_en | input | 1 | Write one entry at the clock edge |
| fill_vpn | input | VPN_W | Fill page number |
| fill_pid | input | PID_W | Fill process tag |
| fill_ppn | input | PPN_W | Fill physical page |
| fill_perm | input | 3 | Fill rights |
| flush_all | input | 1 | Empty every slot |
| flush_pid_en | input | 1 | Empty the slots of flush_pid |
| flush_pid | input | PID_W | Tag to flush |

## Verification
The assertions assume that the buffer is changed only through the fill port, so two valid slots never share a VPN/PID pair. They also assume that a flush in the same cycle as a fill takes precedence. The stimulus keeps within this by driving fills, flushes and lookups from single tasks that always set every control input. Lookups are made in cycles without a fill, so each compared result reflects the contents committed at the previous edge.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

  localparam int PERM_W = 3;
  localparam int ACC_W  = 2;

  typedef enum logic [ACC_W-1:0] {
    ACC_RD  = 2'b00,
    ACC_WR  = 2'b01,
    ACC_EX  = 2'b10,
    ACC_RSV = 2'b11
  } acc_e;

  // rights layout: [0] read, [1] write, [2] execute
  function automatic logic perm_allows(logic [PERM_W-1:0] perm, logic [ACC_W-1:0] acc);
    logic ok;
    case (acc)
      ACC_RD:  ok = perm[0];
      ACC_WR:  ok = perm[1];
      ACC_EX:  ok = perm[2];
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/tlb_slot.sv
module tlb_slot
  import tlbx_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PPN_W = 16,
  parameter int PID_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_all,
  input  logic              flush_pid_en,
  input  logic [PID_W-1:0]  flush_pid,
  input  logic              wr,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PID_W-1:0]  wr_pid,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic [VPN_W-1:0]  q_vpn,
  input  logic [PID_W-1:0]  q_pid,
  output logic              valid,
  output logic              q_match,
  output logic              f_match,
  output logic [PPN_W-1:0]  ppn,
  output logic [PERM_W-1:0] perm,
  output logic [PID_W-1:0]  pid
);

  logic [VPN_W-1:0] vpn_q;
  logic             kill;

  assign kill = flush_all || (flush_pid_en && (pid == flush_pid));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      vpn_q <= '0;
      pid   <= '0;
      ppn   <= '0;
      perm  <= '0;
    end else if (kill) begin
      valid <= 1'b0;
    end else if (wr) begin
      valid <= 1'b1;
      vpn_q <= wr_vpn;
      pid   <= wr_pid;
      ppn   <= wr_ppn;
      perm  <= wr_perm;
    end
  end

  assign q_match = valid && (vpn_q == q_vpn)  && (pid == q_pid);
  assign f_match = valid && (vpn_q == wr_vpn) && (pid == wr_pid);

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] fmatch_vec,
  output logic [ENTRIES-1:0] sel_vec,
  output logic               rr_step
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr;

  function automatic logic [ENTRIES-1:0] lowest_free(logic [ENTRIES-1:0] v);
    logic [ENTRIES-1:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!v[i]) begin
        r    = '0;
        r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [ENTRIES-1:0] idx_onehot(logic [IDX_W-1:0] k);
    logic [ENTRIES-1:0] r;
    r    = '0;
    r[k] = 1'b1;
    return r;
  endfunction

  always_comb begin
    if (|fmatch_vec)      sel_vec = fmatch_vec;
    else if (!(&valid_vec)) sel_vec = lowest_free(valid_vec);
    else                  sel_vec = idx_onehot(ptr);
  end

  assign rr_step = commit && !(|fmatch_vec) && (&valid_vec);

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (rr_step) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

endmodule

// File: rtl/tlb_readout.sv
module tlb_readout
  import tlbx_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PPN_W   = 16
) (
  input  logic [ENTRIES-1:0]             match_vec,
  input  logic [ENTRIES-1:0][PPN_W-1:0]  slot_ppn,
  input  logic [ENTRIES-1:0][PERM_W-1:0] slot_perm,
  input  logic [ACC_W-1:0]               acc,
  output logic                           hit,
  output logic                           fault,
  output logic [PPN_W-1:0]               ppn,
  output logic [PERM_W-1:0]              perm
);

  logic [PPN_W-1:0] ppn_or;
  logic             any;
  logic             allowed;

  always_comb begin
    ppn_or = '0;
    perm   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) begin
        ppn_or = ppn_or | slot_ppn[i];
        perm   = perm   | slot_perm[i];
      end
    end
  end

  assign any     = |match_vec;
  assign allowed = perm_allows(perm, acc);
  assign hit     = any && allowed;
  assign fault   = any && !allowed;
  assign ppn     = hit ? ppn_or : '0;

endmodule

// File: rtl/tagged_tlb.sv
module tagged_tlb
  import tlbx_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 16,
  parameter int PID_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [PID_W-1:0]  lk_pid,
  input  logic [1:0]        lk_acc,
  output logic              lk_hit,
  output logic              lk_fault,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [2:0]        lk_perm,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PID_W-1:0]  fill_pid,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [2:0]        fill_perm,
  input  logic              flush_all,
  input  logic              flush_pid_en,
  input  logic [PID_W-1:0]  flush_pid
);

  // named internal events, visible to the checker
  logic                           fill_commit;
  logic                           rr_step;
  logic [ENTRIES-1:0]             valid_vec;
  logic [ENTRIES-1:0]             lk_match_vec;
  logic [ENTRIES-1:0]             fill_match_vec;
  logic [ENTRIES-1:0]             sel_vec;
  logic [ENTRIES-1:0][PPN_W-1:0]  slot_ppn;
  logic [ENTRIES-1:0][PERM_W-1:0] slot_perm;
  logic [ENTRIES-1:0][PID_W-1:0]  slot_pid;

  assign fill_commit = fill_en && !flush_all && !flush_pid_en;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    tlb_slot #(
      .VPN_W(VPN_W), .PPN_W(PPN_W), .PID_W(PID_W)
    ) u_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush_all    (flush_all),
      .flush_pid_en (flush_pid_en),
      .flush_pid    (flush_pid),
      .wr           (fill_commit && sel_vec[g]),
      .wr_vpn       (fill_vpn),
      .wr_pid       (fill_pid),
      .wr_ppn       (fill_ppn),
      .wr_perm      (fill_perm),
      .q_vpn        (lk_vpn),
      .q_pid        (lk_pid),
      .valid        (valid_vec[g]),
      .q_match      (lk_match_vec[g]),
      .f_match      (fill_match_vec[g]),
      .ppn          (slot_ppn[g]),
      .perm         (slot_perm[g]),
      .pid          (slot_pid[g])
    );
  end

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (fill_commit),
    .valid_vec  (valid_vec),
    .fmatch_vec (fill_match_vec),
    .sel_vec    (sel_vec),
    .rr_step    (rr_step)
  );

  tlb_readout #(.ENTRIES(ENTRIES), .PPN_W(PPN_W)) u_read (
    .match_vec (lk_match_vec),
    .slot_ppn  (slot_ppn),
    .slot_perm (slot_perm),
    .acc       (lk_acc),
    .hit       (lk_hit),
    .fault     (lk_fault),
    .ppn       (lk_ppn),
    .perm      (lk_perm)
  );

endmodule

// File: rtl/tagged_tlb_chk.sv
module tagged_tlb_chk #(
  parameter int ENTRIES = 8,
  parameter int PPN_W   = 16,
  parameter int PID_W   = 6
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          lk_hit,
  input logic                          lk_fault,
  input logic [PPN_W-1:0]              lk_ppn,
  input logic [2:0]                    lk_perm,
  input logic                          fill_commit,
  input logic                          flush_all,
  input logic                          flush_pid_en,
  input logic [PID_W-1:0]              flush_pid,
  input logic [ENTRIES-1:0]            valid_vec,
  input logic [ENTRIES-1:0]            lk_match_vec,
  input logic [ENTRIES-1:0][PID_W-1:0] slot_pid
);

  logic             pf_q;
  logic [PID_W-1:0] pf_pid_q;
  logic             tag_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_q     <= 1'b0;
      pf_pid_q <= '0;
    end else begin
      pf_q     <= flush_pid_en;
      pf_pid_q <= flush_pid;
    end
  end

  always_comb begin
    tag_left = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (valid_vec[i] && slot_pid[i] == pf_pid_q) tag_left = 1'b1;
  end

  // R11
  hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_fault));

  // R11
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_match_vec == '0) |-> (lk_ppn == '0 && lk_perm == '0 && !lk_hit && !lk_fault));

  // R4
  fault_no_ppn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> (lk_ppn == '0));

  // R7
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match_vec));

  // R8
  flush_all_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_vec == '0));

  // R9
  flush_tag_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_q |-> !tag_left);

  // R2
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_commit |=> (valid_vec != '0));

endmodule

bind tagged_tlb tagged_tlb_chk #(
  .ENTRIES(ENTRIES), .PPN_W(PPN_W), .PID_W(PID_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lk_hit       (lk_hit),
  .lk_fault     (lk_fault),
  .lk_ppn       (lk_ppn),
  .lk_perm      (lk_perm),
  .fill_commit  (fill_commit),
  .flush_all    (flush_all),
  .flush_pid_en (flush_pid_en),
  .flush_pid    (flush_pid),
  .valid_vec    (valid_vec),
  .lk_match_vec (lk_match_vec),
  .slot_pid     (slot_pid)
);

// File: tb/sim_tagged_tlb.sv
`timescale 1ns/100ps
module sim_tagged_tlb;

  localparam int N     = 8;
  localparam int VPN_W = 20;
  localparam int PPN_W = 16;
  localparam int PID_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic [PID_W-1:0] lk_pid = '0;
  logic [1:0]       lk_acc = '0;
  logic             lk_hit, lk_fault;
  logic [PPN_W-1:0] lk_ppn;
  logic [2:0]       lk_perm;
  logic             fill_en = 1'b0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [PID_W-1:0] fill_pid = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic [2:0]       fill_perm = '0;
  logic             flush_all = 1'b0;
  logic             flush_pid_en = 1'b0;
  logic [PID_W-1:0] flush_pid = '0;

  always #2.5 clk = ~clk;

  tagged_tlb #(.ENTRIES(N), .VPN_W(VPN_W), .PPN_W(PPN_W), .PID_W(PID_W)) u0 (.*);

  // reference contents
  logic             m_v   [N];
  logic [VPN_W-1:0] m_vpn [N];
  logic [PID_W-1:0] m_pid [N];
  logic [PPN_W-1:0] m_ppn [N];
  logic [2:0]       m_perm[N];
  int               m_ptr;

  typedef struct {
    logic             hit;
    logic             fault;
    logic [PPN_W-1:0] ppn;
    logic [2:0]       perm;
    string            rq;
  } exp_t;
  exp_t sb[$];

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  task automatic set_idle();
    fill_en = 0; flush_all = 0; flush_pid_en = 0;
  endtask

  task automatic do_lookup(input logic [VPN_W-1:0] v, input logic [PID_W-1:0] p,
                           input logic [1:0] a, input string rq);
    exp_t e;
    int   k;
    @(negedge clk);
    set_idle();
    lk_vpn = v; lk_pid = p; lk_acc = a;
    k = -1;
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == v && m_pid[i] == p) k = i;
    e.rq = rq; e.hit = 0; e.fault = 0; e.ppn = '0; e.perm = '0;
    if (k >= 0) begin
      logic ok;
      ok = (a == 2'd0) ? m_perm[k][0] : (a == 2'd1) ? m_perm[k][1] :
           (a == 2'd2) ? m_perm[k][2] : 1'b0;
      e.perm  = m_perm[k];
      e.hit   = ok;
      e.fault = !ok;
      e.ppn   = ok ? m_ppn[k] : '0;
    end
    sb.push_back(e);
  endtask

  task automatic do_fill(input logic [VPN_W-1:0] v, input logic [PID_W-1:0] p,
                         input logic [PPN_W-1:0] pp, input logic [2:0] pm,
                         input bit fa, input bit fp, input logic [PID_W-1:0] fpid);
    int k;
    @(negedge clk);
    fill_en = 1; fill_vpn = v; fill_pid = p; fill_ppn = pp; fill_perm = pm;
    flush_all = fa; flush_pid_en = fp; flush_pid = fpid;
    if (fa) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else if (fp) begin
      for (int i = 0; i < N; i++) if (m_pid[i] == fpid) m_v[i] = 0;
    end else begin
      k = -1;
      for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == v && m_pid[i] == p) k = i;
      if (k < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) k = i;
      if (k < 0) begin k = m_ptr; m_ptr = (m_ptr + 1) % N; end
      m_v[k] = 1; m_vpn[k] = v; m_pid[k] = p; m_ppn[k] = pp; m_perm[k] = pm;
    end
  endtask

  task automatic do_flush(input bit fa, input bit fp, input logic [PID_W-1:0] fpid);
    @(negedge clk);
    fill_en = 0; flush_all = fa; flush_pid_en = fp; flush_pid = fpid;
    for (int i = 0; i < N; i++)
      if (fa || (fp && m_pid[i] == fpid)) m_v[i] = 0;
  endtask

  // monitor: compares one queued expectation per cycle, away from the edge
  always @(negedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (lk_hit !== e.hit || lk_fault !== e.fault || lk_ppn !== e.ppn || lk_perm !== e.perm) begin
        bad++;
        $display("FAIL %s: got hit=%0b fault=%0b ppn=%h perm=%b exp hit=%0b fault=%0b ppn=%h perm=%b",
                 e.rq, lk_hit, lk_fault, lk_ppn, lk_perm, e.hit, e.fault, e.ppn, e.perm);
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got running exp finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_vpn[i] = '0; m_pid[i] = '0; m_ppn[i] = '0; m_perm[i] = '0;
    end
    m_ptr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: empty after reset
    do_lookup(20'h00000, 6'd0, 2'd0, "R1");
    do_lookup(20'h00100, 6'd1, 2'd1, "R1");

    // R2 / R4: fill, then allowed and forbidden accesses
    do_fill(20'h00100, 6'd1, 16'h0011, 3'b011, 0, 0, '0);
    do_lookup(20'h00100, 6'd1, 2'd0, "R2");
    do_lookup(20'h00100, 6'd1, 2'd1, "R2");
    do_lookup(20'h00100, 6'd1, 2'd2, "R4");
    do_lookup(20'h00100, 6'd1, 2'd3, "R4");
    // R3: tag must agree
    do_lookup(20'h00100, 6'd2, 2'd0, "R3");
    do_lookup(20'h00101, 6'd1, 2'd0, "R11");

    // R5: fill the rest, nothing evicted
    for (int i = 1; i < N; i++)
      do_fill(20'h00100 + i, 6'd1, 16'h0020 + i, 3'b101, 0, 0, '0);
    for (int i = 0; i < N; i++) do_lookup(20'h00100 + i, 6'd1, 2'd0, "R5");

    // R7: refill an existing pair in place
    do_fill(20'h00103, 6'd1, 16'h0BEE, 3'b111, 0, 0, '0);
    for (int i = 0; i < N; i++) do_lookup(20'h00100 + i, 6'd1, 2'd1, "R7");

    // R6: rotating eviction starts at slot 0 (R7 must not have advanced it)
    do_fill(20'h00200, 6'd2, 16'h0200, 3'b001, 0, 0, '0);
    do_fill(20'h00201, 6'd2, 16'h0201, 3'b001, 0, 0, '0);
    do_lookup(20'h00100, 6'd1, 2'd0, "R6");
    do_lookup(20'h00101, 6'd1, 2'd0, "R6");
    do_lookup(20'h00102, 6'd1, 2'd0, "R6");
    do_lookup(20'h00200, 6'd2, 2'd0, "R6");
    do_lookup(20'h00201, 6'd2, 2'd0, "R6");

    // R9: flush one tag only
    do_flush(0, 1, 6'd2);
    do_lookup(20'h00200, 6'd2, 2'd0, "R9");
    do_lookup(20'h00201, 6'd2, 2'd0, "R9");
    for (int i = 2; i < N; i++) do_lookup(20'h00100 + i, 6'd1, 2'd0, "R9");

    // R3: same page, two tags, distinct frames
    do_fill(20'h00300, 6'd3, 16'h0303, 3'b001, 0, 0, '0);
    do_fill(20'h00300, 6'd4, 16'h0404, 3'b001, 0, 0, '0);
    do_lookup(20'h00300, 6'd3, 2'd0, "R3");
    do_lookup(20'h00300, 6'd4, 2'd0, "R3");
    do_lookup(20'h00104, 6'd1, 2'd0, "R5");

    // R10: fill dropped when a tag flush shares its cycle
    do_fill(20'h00400, 6'd5, 16'h0500, 3'b001, 0, 1, 6'd3);
    do_lookup(20'h00400, 6'd5, 2'd0, "R10");
    do_lookup(20'h00300, 6'd3, 2'd0, "R9");
    do_lookup(20'h00300, 6'd4, 2'd0, "R9");

    // R10 / R8: fill together with a full flush
    do_fill(20'h00500, 6'd6, 16'h0600, 3'b001, 1, 0, '0);
    do_lookup(20'h00500, 6'd6, 2'd0, "R10");
    for (int i = 0; i < N; i++) do_lookup(20'h00100 + i, 6'd1, 2'd0, "R8");
    do_lookup(20'h00300, 6'd4, 2'd0, "R8");

    // R5 after flush: free slots reused, all resident
    for (int i = 0; i < N; i++)
      do_fill(20'h00700 + i, 6'd7, 16'h0700 + i, 3'b010, 0, 0, '0);
    for (int i = 0; i < N; i++) do_lookup(20'h00700 + i, 6'd7, 2'd1, "R5");
    do_lookup(20'h00700, 6'd7, 2'd0, "R4");

    @(negedge clk); set_idle();
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule